// File: doc/BRIEF.md
# Two-Bank Memory Card Bus Lane Decoder

This block sits between a host bus and a memory card built from two 8-bit banks: an even bank that holds the low-order byte of each 16-bit word and an odd bank that holds the high-order byte. From the two active-low card enables, address bit 0, output enable and write enable, it derives a select, a read strobe and a write strobe for each bank. It also steers data between the banks and the host bus, which runs either 16 bits wide or 8 bits wide on its low lane.

With both card enables low the card works word-wide. The even bank owns bus bits 7:0, the odd bank owns bits 15:8, and address bit 0 has no effect. With the first enable low and the second high the card works byte-wide. Address bit 0 then picks one bank, and that bank's byte moves over bus bits 7:0 in both directions. Each bus lane has its own drive enable, so a lane whose bank is not selected stays undriven. A write-protect switch input blocks every write strobe. Two card-detect inputs combine into a single seated flag.

The decode is purely combinational. The clock and reset inputs exist only for the timing frame of the bound checker.

Top module: `card_lane_steer`

## Requirements
- R1: With ce1_n=0 and ce2_n=0 (word mode), lo_sel and hi_sel are both 1 for either value of a0.
- R2: With ce1_n=0 and ce2_n=1 (byte mode), a0=0 gives lo_sel=1, hi_sel=0, and a0=1 gives lo_sel=0, hi_sel=1.
- R3: With ce1_n=1, both selects and all strobes are 0 and both lane enables are 0, whatever the value of ce2_n.
- R4: A word-mode read (oe_n=0) drives dq_out[7:0] from lo_rdata and dq_out[15:8] from hi_rdata, with lane_lo_oe=1 and lane_hi_oe=1.
- R5: A byte-mode read (oe_n=0) drives dq_out[7:0] from lo_rdata when a0=0 and from hi_rdata when a0=1. lane_hi_oe stays 0 in byte mode.
- R6: With oe_n=1, lane_lo_oe, lane_hi_oe, lo_rd and hi_rd are all 0.
- R7: A lane whose enable is 0 presents all zeros on its part of dq_out.
- R8: A bank's read strobe is 1 exactly when that bank is selected and oe_n=0.
- R9: A bank's write strobe is 1 only when that bank is selected, we_n=0, oe_n=1 and wp_on=0.
- R10: With wp_on=1, lo_wr and hi_wr are both 0 for every other input.
- R11: Write data goes to lo_wdata from dq_in[7:0]. hi_wdata takes dq_in[15:8] in word mode and dq_in[7:0] in byte mode.
- R12: card_seated is 1 only when cd1_n=0 and cd2_n=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bound checker only |
| rst_n | input | 1 | Active-low reset for the bound checker only |
| ce1_n | input | 1 | Card enable for the low lane, active low |
| ce2_n | input | 1 | Card enable for the high lane, active low |
| a0 | input | 1 | Address bit 0; picks the bank in byte mode |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_on | input | 1 | Write-protect switch, 1 = protected |
| cd1_n | input | 1 | Card detect 1, low when seated |
| cd2_n | input | 1 | Card detect 2, low when seated |
| dq_in | input | 2*LANE_W | Host write data |
| dq_out | output | 2*LANE_W | Host read data |
| lane_lo_oe | output | 1 | Drive enable for bus bits 7:0 |
| lane_hi_oe | output | 1 | Drive enable for bus bits 15:8 |
| lo_rdata | input | LANE_W | Read data from the even bank |
| hi_rdata | input | LANE_W | Read data from the odd bank |
| lo_sel | output | 1 | Even bank select |
| hi_sel | output | 1 | Odd bank select |
| lo_rd | output | 1 | Even bank read strobe |
| hi_rd | output | 1 | Odd bank read strobe |
| lo_wr | output | 1 | Even bank write strobe |
| hi_wr | output | 1 | Odd bank write strobe |
| lo_wdata | output | LANE_W | Write data to the even bank |
| hi_wdata | output | LANE_W | Write data to the odd bank |
| card_seated | output | 1 | Both card-detect inputs are low |

## Verification
In byte mode the bench reads with a0=1 and expects the odd bank's byte on the low lane. A design that forgot the cross-lane multiplex would show the even byte there, or would put the odd byte on the upper lane and enable that lane. A byte-mode write with a0=1 must carry bits 7:0 into the odd bank. A design that wired the odd bank to the upper bits would write whatever pattern sits on the upper bits, which the bench loads with different data. The bench also drives ce1_n=1 with ce2_n=0, which catches a decoder that treats the second enable alone as a byte select. It applies write enable while output enable is low, and while write protect is on, and in both cases expects no write strobe at all. Finally it tries each one-sided card-detect pattern, which exposes a seated flag built from OR instead of AND.

// File: rtl/card_lane_steer.sv
module card_lane_steer #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce1_n,
  input  logic                ce2_n,
  input  logic                a0,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic                wp_on,
  input  logic                cd1_n,
  input  logic                cd2_n,
  input  logic [2*LANE_W-1:0] dq_in,
  output logic [2*LANE_W-1:0] dq_out,
  output logic                lane_lo_oe,
  output logic                lane_hi_oe,
  input  logic [LANE_W-1:0]   lo_rdata,
  input  logic [LANE_W-1:0]   hi_rdata,
  output logic                lo_sel,
  output logic                hi_sel,
  output logic                lo_rd,
  output logic                hi_rd,
  output logic                lo_wr,
  output logic                hi_wr,
  output logic [LANE_W-1:0]   lo_wdata,
  output logic [LANE_W-1:0]   hi_wdata,
  output logic                card_seated
);

  logic word_mode, byte_mode, we_eff, odd_byte;
  logic [LANE_W-1:0] lo_lane, hi_lane;

  assign word_mode = ~ce1_n & ~ce2_n;
  assign byte_mode = ~ce1_n &  ce2_n;
  assign odd_byte  = byte_mode & a0;

  assign lo_sel = word_mode | (byte_mode & ~a0);
  assign hi_sel = word_mode | odd_byte;

  assign lo_rd = lo_sel & ~oe_n;
  assign hi_rd = hi_sel & ~oe_n;

  assign we_eff = ~we_n & oe_n & ~wp_on;
  assign lo_wr  = lo_sel & we_eff;
  assign hi_wr  = hi_sel & we_eff;

  assign lo_wdata = dq_in[LANE_W-1:0];
  assign hi_wdata = byte_mode ? dq_in[LANE_W-1:0] : dq_in[2*LANE_W-1:LANE_W];

  assign lane_lo_oe = ~oe_n & ~ce1_n;
  assign lane_hi_oe = ~oe_n & word_mode;

  assign lo_lane = odd_byte ? hi_rdata : lo_rdata;
  assign hi_lane = hi_rdata;

  assign dq_out = {(lane_hi_oe ? hi_lane : '0), (lane_lo_oe ? lo_lane : '0)};

  assign card_seated = ~cd1_n & ~cd2_n;

  logic unused_ok;
  assign unused_ok = clk ^ rst_n;

endmodule

// File: rtl/card_lane_steer_chk.sv
module card_lane_steer_chk #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce1_n,
  input logic                ce2_n,
  input logic                a0,
  input logic                oe_n,
  input logic                we_n,
  input logic                wp_on,
  input logic                cd1_n,
  input logic                cd2_n,
  input logic [2*LANE_W-1:0] dq_in,
  input logic [2*LANE_W-1:0] dq_out,
  input logic                lane_lo_oe,
  input logic                lane_hi_oe,
  input logic [LANE_W-1:0]   lo_rdata,
  input logic [LANE_W-1:0]   hi_rdata,
  input logic                lo_sel,
  input logic                hi_sel,
  input logic                lo_rd,
  input logic                hi_rd,
  input logic                lo_wr,
  input logic                hi_wr,
  input logic [LANE_W-1:0]   lo_wdata,
  input logic [LANE_W-1:0]   hi_wdata,
  input logic                card_seated
);

  // R3
  deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce1_n |-> !(lo_sel | hi_sel | lo_rd | hi_rd | lo_wr | hi_wr | lane_lo_oe | lane_hi_oe));

  // R2
  byte_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && ce2_n) |-> $onehot({lo_sel, hi_sel}) && (hi_sel == a0));

  // R1
  word_both_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce1_n && !ce2_n) |-> (lo_sel && hi_sel));

  // R6
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !(lane_lo_oe || lane_hi_oe || lo_rd || hi_rd));

  // R10
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_on |-> !(lo_wr || hi_wr));

  // R9
  wr_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr || hi_wr) |-> (!we_n && oe_n && (lo_wr ? lo_sel : 1'b1) && (hi_wr ? hi_sel : 1'b1)));

  // R5
  byte_hi_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce2_n |-> !lane_hi_oe);

  // R7
  idle_lanes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lane_lo_oe && !lane_hi_oe) |-> (dq_out == '0));

  // R12
  seated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_seated |-> (!cd1_n && !cd2_n));

  // R8
  rd_never_with_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((lo_rd || hi_rd) && (lo_wr || hi_wr)));

endmodule

bind card_lane_steer card_lane_steer_chk #(.LANE_W(LANE_W)) chk (.*);

// File: tb/tb_card_lane_steer.sv
`timescale 1ns/1ps
module tb_card_lane_steer;
  localparam int LANE_W = 8;

  logic clk = 0, rst_n = 0;
  logic ce1_n = 1, ce2_n = 1, a0 = 0, oe_n = 1, we_n = 1, wp_on = 0, cd1_n = 1, cd2_n = 1;
  logic [15:0] dq_in = '0;
  logic [7:0]  lo_rdata = 8'h3C, hi_rdata = 8'hA5;
  logic [15:0] dq_out;
  logic lane_lo_oe, lane_hi_oe, lo_sel, hi_sel, lo_rd, hi_rd, lo_wr, hi_wr, card_seated;
  logic [7:0] lo_wdata, hi_wdata;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  card_lane_steer #(.LANE_W(LANE_W)) dut (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2_n(ce2_n), .a0(a0), .oe_n(oe_n),
    .we_n(we_n), .wp_on(wp_on), .cd1_n(cd1_n), .cd2_n(cd2_n), .dq_in(dq_in),
    .dq_out(dq_out), .lane_lo_oe(lane_lo_oe), .lane_hi_oe(lane_hi_oe),
    .lo_rdata(lo_rdata), .hi_rdata(hi_rdata), .lo_sel(lo_sel), .hi_sel(hi_sel),
    .lo_rd(lo_rd), .hi_rd(hi_rd), .lo_wr(lo_wr), .hi_wr(hi_wr),
    .lo_wdata(lo_wdata), .hi_wdata(hi_wdata), .card_seated(card_seated)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic c1, logic c2, logic a, logic oe, logic we, logic wp);
    @(negedge clk);
    ce1_n = c1; ce2_n = c2; a0 = a; oe_n = oe; we_n = we; wp_on = wp;
    #1;
  endtask

  task automatic t_idle();
    apply(1, 1, 0, 0, 0, 0);
    check("R3 idle sel/strobes", {lo_sel, hi_sel, lo_rd, hi_rd, lo_wr, hi_wr}, 0);
    check("R7 idle dq_out", dq_out, 0);
    apply(1, 0, 1, 0, 0, 0);
    check("R3 ce2 alone sel/strobes", {lo_sel, hi_sel, lo_rd, hi_rd, lo_wr, hi_wr}, 0);
    check("R3 ce2 alone lanes", {lane_lo_oe, lane_hi_oe}, 0);
  endtask

  task automatic t_word_read();
    for (int a = 0; a < 2; a++) begin
      apply(0, 0, a[0], 0, 1, 0);
      check("R1 word sel", {lo_sel, hi_sel}, 2'b11);
      check("R4 word dq_out", dq_out, 16'hA53C);
      check("R4 word lanes", {lane_lo_oe, lane_hi_oe}, 2'b11);
      check("R8 word rd", {lo_rd, hi_rd}, 2'b11);
    end
  endtask

  task automatic t_byte_read();
    apply(0, 1, 0, 0, 1, 0);
    check("R2 byte a0=0 sel", {lo_sel, hi_sel}, 2'b10);
    check("R5 byte even dq_out", dq_out, 16'h003C);
    check("R8 byte even rd", {lo_rd, hi_rd}, 2'b10);
    apply(0, 1, 1, 0, 1, 0);
    check("R2 byte a0=1 sel", {lo_sel, hi_sel}, 2'b01);
    check("R5 byte odd dq_out", dq_out, 16'h00A5);
    check("R5 byte lanes", {lane_lo_oe, lane_hi_oe}, 2'b10);
    check("R8 byte odd rd", {lo_rd, hi_rd}, 2'b01);
  endtask

  task automatic t_oe_off();
    apply(0, 0, 0, 1, 1, 0);
    check("R6 oe high lanes/rd", {lane_lo_oe, lane_hi_oe, lo_rd, hi_rd}, 0);
    check("R7 oe high dq_out", dq_out, 0);
  endtask

  task automatic t_writes();
    dq_in = 16'h1234;
    apply(0, 0, 1, 1, 0, 0);
    check("R9 word wr", {lo_wr, hi_wr}, 2'b11);
    check("R11 word wdata", {hi_wdata, lo_wdata}, 16'h1234);
    dq_in = 16'h5EC7;
    apply(0, 1, 1, 1, 0, 0);
    check("R9 byte odd wr", {lo_wr, hi_wr}, 2'b01);
    check("R11 byte odd wdata", hi_wdata, 8'hC7);
    apply(0, 1, 0, 1, 0, 0);
    check("R9 byte even wr", {lo_wr, hi_wr}, 2'b10);
    check("R11 byte even wdata", lo_wdata, 8'hC7);
    apply(0, 0, 0, 0, 0, 0);
    check("R9 wr with oe low", {lo_wr, hi_wr}, 0);
    apply(0, 0, 0, 1, 1, 0);
    check("R9 no wr with we high", {lo_wr, hi_wr}, 0);
  endtask

  task automatic t_protect();
    dq_in = 16'hFFFF;
    apply(0, 0, 0, 1, 0, 1);
    check("R10 wp word", {lo_wr, hi_wr}, 0);
    apply(0, 1, 1, 1, 0, 1);
    check("R10 wp byte", {lo_wr, hi_wr}, 0);
  endtask

  task automatic t_seat();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cd1_n = k[0]; cd2_n = k[1];
      #1;
      check("R12 seated", card_seated, (k == 0) ? 1 : 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_idle();
    t_word_read();
    t_byte_read();
    lo_rdata = 8'h81; hi_rdata = 8'h7E;
    apply(0, 1, 1, 0, 1, 0);
    check("R5 byte odd second pattern", dq_out, 16'h007E);
    apply(0, 0, 1, 0, 1, 0);
    check("R4 word second pattern", dq_out, 16'h7E81);
    t_oe_off();
    t_writes();
    t_protect();
    t_seat();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule